// File: doc/BRIEF.md
# Handshaked Pattern Line Loader

The block takes 16-bit words from an outside controller whose timing is unrelated to the chip clock. Transfers use a four-phase handshake. The block drives a ready line, and the controller answers on a valid line. The valid line goes through a synchroniser before the block acts on it.

Six accepted words make up one 96-bit line: a 32-bit repeat count followed by a 64-bit channel pattern. Each complete line is written into a 256-line pattern RAM at an address that advances on its own. A registered read port lets the sequencer fetch lines while loading goes on, so one line can be rewritten while another is being played.

An active-low reset returns the loader to an empty state. It is used at start-up and to recover after a transfer error.

Top module: `pulse_pattern_loader`

## Requirements
- R1: While rst_ni is low, rx_ready_o and rd_line_o are 0. At the first rising clock edge after release, with tx_valid_i low, rx_ready_o goes to 1, and the next word starts a new line at address 0.
- R2: tx_valid_i passes through a two-stage synchroniser. A word offered while rx_ready_o is 1 is captured at the third rising edge after tx_valid_i rises, and rx_ready_o reads 0 after that edge.
- R3: A word is captured only at an edge where rx_ready_o and the synchronised valid are both 1, and that capture drives rx_ready_o to 0.
- R4: rx_ready_o stays 0 for as long as tx_valid_i stays 1. It returns to 1 at the third rising edge after tx_valid_i falls.
- R5: Word order within a line is fixed. Words 0 and 1 are repeat count bits 31:16 and 15:0. Words 2 to 5 are pattern bits 63:48, 47:32, 31:16 and 15:0. The stored line is {repeat[31:0], pattern[63:0]}, with the repeat count in bits 95:64.
- R6: Exactly six captured words form one line. The line is written at the edge that captures the sixth word, and then the line address advances by one.
- R7: After line 255 the address wraps to 0, and the next line overwrites line 0 while leaving line 255 intact.
- R8: A reset in the middle of a line discards the partial words and sets the address back to 0. It does not change lines already stored in the RAM.
- R9: With rd_en_i high at an edge, rd_line_o shows the line at rd_addr_i after that edge. Reads work while loading is in progress. A read of the address being written at the same edge returns the line's previous contents.
- R10: Values on data_i at edges other than a capture edge have no effect on stored lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Generic loader clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 16 | Data word from the controller |
| tx_valid_i | input | 1 | Controller valid, asynchronous to clk_i |
| rx_ready_o | output | 1 | Loader ready to take a word |
| rd_en_i | input | 1 | Read strobe from the sequencer |
| rd_addr_i | input | 8 | Line address to read |
| rd_line_o | output | 96 | Registered line read data |

## Verification
The bench counts edges from each valid change to the matching ready change. A design that dropped a synchroniser stage, or sampled too early, would show a latency other than three. It holds valid high for extra cycles: a loader that re-armed ready early would take a duplicate word and shift every later line by one position.

The bench fills all 256 lines and then writes one more, which catches a missing address wrap. In the same test it reads line 0 at the exact edge where line 0 is rewritten; a write-first RAM would return the new line there. It also resets in the middle of a line, which exposes a word counter or partial register that survives reset, and it puts garbage on data_i between beats to catch capture at the wrong edge.

// File: rtl/pulse_loader_pkg.sv
`timescale 1ns/1ps
package pulse_loader_pkg;
  localparam int unsigned WORD_W_DEF      = 16;
  localparam int unsigned WORDS_DEF       = 6;
  localparam int unsigned DEPTH_DEF       = 256;
  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/pulse_loader_sync.sv
`timescale 1ns/1ps
module pulse_loader_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pulse_loader_hs.sv
`timescale 1ns/1ps
module pulse_loader_hs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_sync_i,
  output logic rx_ready_o,
  output logic accept_o
);
  logic rdy_q;

  assign accept_o   = rdy_q & tx_sync_i;
  assign rx_ready_o = rdy_q;

  // four-phase: drop on capture, re-arm only once valid is seen low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rdy_q <= 1'b0;
    else if (accept_o)            rdy_q <= 1'b0;
    else if (!rdy_q && !tx_sync_i) rdy_q <= 1'b1;
  end

  assert_fall_on_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_q && tx_sync_i) |=> !rdy_q);

  assert_no_rearm_while_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_q && tx_sync_i) |=> !rdy_q);

  assert_rearm_after_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_q) |-> !$past(tx_sync_i));
endmodule

// File: rtl/pulse_loader_pack.sv
`timescale 1ns/1ps
module pulse_loader_pack #(
  parameter  int unsigned WORD_W = 16,
  parameter  int unsigned WORDS  = 6,
  parameter  int unsigned DEPTH  = 256,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned LINE_W = WORD_W * WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [LINE_W-1:0] wline_o
);
  localparam int unsigned CNT_W  = $clog2(WORDS);
  localparam int unsigned PART_W = WORD_W * (WORDS - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PART_W-1:0] part_q;
  logic              last;

  assign last    = (cnt_q == CNT_W'(WORDS - 1));
  assign we_o    = accept_i & last;
  assign waddr_o = addr_q;
  // final beat goes straight from the port into the line
  assign wline_o = {part_q, data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
      part_q <= '0;
    end else if (accept_i) begin
      if (last) begin
        cnt_q  <= '0;
        addr_q <= (addr_q == ADDR_W'(DEPTH - 1)) ? '0 : addr_q + 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        part_q <= PART_W'({part_q, data_i});
      end
    end
  end

  assert_cnt_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(WORDS));

  assert_addr_hold_mid_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_i && last) |=> $stable(addr_q));

  assert_addr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && last && addr_q != ADDR_W'(DEPTH - 1)) |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

  assert_addr_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && last && addr_q == ADDR_W'(DEPTH - 1)) |=> addr_q == '0);
endmodule

// File: rtl/pulse_loader_ram.sv
`timescale 1ns/1ps
module pulse_loader_ram #(
  parameter  int unsigned LINE_W = 96,
  parameter  int unsigned DEPTH  = 256,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LINE_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [LINE_W-1:0] rdata_o
);
  logic [LINE_W-1:0] mem_q [DEPTH];
  logic [LINE_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read-before-write on a shared address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;

  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_q));
endmodule

// File: rtl/pulse_pattern_loader.sv
`timescale 1ns/1ps
module pulse_pattern_loader
  import pulse_loader_pkg::*;
#(
  parameter  int unsigned WORD_W      = WORD_W_DEF,
  parameter  int unsigned WORDS       = WORDS_DEF,
  parameter  int unsigned DEPTH       = DEPTH_DEF,
  parameter  int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  localparam int unsigned LINE_W      = WORD_W * WORDS,
  localparam int unsigned ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic              tx_valid_i,
  output logic              rx_ready_o,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [LINE_W-1:0] rd_line_o
);
  logic              tx_sync;
  logic              accept;
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [LINE_W-1:0] wline;

  pulse_loader_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tx_valid_i),
    .q_o   (tx_sync)
  );

  pulse_loader_hs u_hs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_sync_i (tx_sync),
    .rx_ready_o(rx_ready_o),
    .accept_o  (accept)
  );

  pulse_loader_pack #(.WORD_W(WORD_W), .WORDS(WORDS), .DEPTH(DEPTH)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .data_i  (data_i),
    .we_o    (we),
    .waddr_o (waddr),
    .wline_o (wline)
  );

  pulse_loader_ram #(.LINE_W(LINE_W), .DEPTH(DEPTH)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wline),
    .rd_en_i(rd_en_i),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_line_o)
  );
endmodule

// File: tb/tb_pulse_pattern_loader.sv
`timescale 1ns/1ps
module tb_pulse_pattern_loader;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [15:0] data_r;
  logic        tx_r;
  logic        rd_en_r;
  logic [7:0]  rd_addr_r;
  logic        rx_ready_o;
  logic [95:0] rd_line_o;

  always #2 clk = ~clk;

  pulse_pattern_loader dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .data_i    (data_r),
    .tx_valid_i(tx_r),
    .rx_ready_o(rx_ready_o),
    .rd_en_i   (rd_en_r),
    .rd_addr_i (rd_addr_r),
    .rd_line_o (rd_line_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [95:0] exp_mem [256];
  int exp_addr = 0;
  int lines_loaded = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input logic [31:0] rc, input logic [63:0] pat, input int i);
    case (i)
      0: return rc[31:16];
      1: return rc[15:0];
      2: return pat[63:48];
      3: return pat[47:32];
      4: return pat[31:16];
      default: return pat[15:0];
    endcase
  endfunction

  task automatic send_word(input logic [15:0] w, input int gap, input bit collide,
                           input int caddr, input logic [95:0] old_line);
    int n;
    repeat (gap) begin @(negedge clk); data_r = 16'($urandom); end
    while (!rx_ready_o) @(negedge clk);
    data_r = w;
    tx_r   = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (collide && n == 2) begin rd_en_r = 1'b1; rd_addr_r = 8'(caddr); end
    end while (rx_ready_o);
    if (collide) begin
      rd_en_r = 1'b0;
      chk(rd_line_o === old_line, "R9", "read at rewrite edge", rd_line_o, old_line);
    end
    tx_r   = 1'b0;
    data_r = 16'($urandom);
    do @(negedge clk); while (!rx_ready_o);
  endtask

  task automatic send_line(input logic [31:0] rc, input logic [63:0] pat,
                           input int maxgap, input bit collide);
    logic [95:0] old_line;
    old_line = exp_mem[exp_addr];
    for (int i = 0; i < 6; i++)
      send_word(word_of(rc, pat, i), (maxgap > 0) ? int'($urandom_range(0, maxgap)) : 0,
                collide && (i == 5), exp_addr, old_line);
    exp_mem[exp_addr] = {rc, pat};
    exp_addr = (exp_addr + 1) % 256;
    lines_loaded++;
  endtask

  task automatic read_check(input int addr, input string req);
    @(negedge clk);
    rd_en_r   = 1'b1;
    rd_addr_r = 8'(addr);
    @(negedge clk);
    rd_en_r = 1'b0;
    chk(rd_line_o === exp_mem[addr], req, $sformatf("line %0d", addr), rd_line_o, exp_mem[addr]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rc0;
    logic [63:0] pat0;
    int n;
    bit stayed_low;
    void'($urandom(32'd1207));
    rst_ni = 1'b0; data_r = '0; tx_r = 1'b0; rd_en_r = 1'b0; rd_addr_r = '0;
    repeat (3) @(negedge clk);
    chk(rx_ready_o === 1'b0, "R1", "ready in reset", 96'(rx_ready_o), 96'd0);
    chk(rd_line_o === '0, "R1", "read data in reset", rd_line_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(rx_ready_o === 1'b1, "R1", "ready after release", 96'(rx_ready_o), 96'd1);

    // directed first word: latency both ways, valid held long
    rc0  = 32'hA5C3_0F1E;
    pat0 = 64'h0123_4567_89AB_CDEF;
    data_r = word_of(rc0, pat0, 0);
    tx_r = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (rx_ready_o && n < 10);
    chk(n == 3, "R2", "edges to capture", 96'(n), 96'd3);
    chk(rx_ready_o === 1'b0, "R3", "ready drop on capture", 96'(rx_ready_o), 96'd0);
    data_r = 16'hDEAD;
    stayed_low = 1'b1;
    repeat (5) begin @(negedge clk); if (rx_ready_o !== 1'b0) stayed_low = 1'b0; end
    chk(stayed_low, "R4", "ready low while valid held", 96'(stayed_low), 96'd1);
    tx_r = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!rx_ready_o && n < 10);
    chk(n == 3, "R4", "edges to re-arm", 96'(n), 96'd3);
    for (int i = 1; i < 6; i++) send_word(word_of(rc0, pat0, i), 0, 1'b0, 0, '0);
    exp_mem[0] = {rc0, pat0};
    exp_addr = 1;
    lines_loaded = 1;
    read_check(0, "R5");

    // random lines with gaps and garbage on data_i (R10)
    for (int k = 0; k < 30; k++) send_line($urandom, {$urandom, $urandom}, 4, 1'b0);
    for (int k = 1; k <= 30; k++) read_check(k, (k % 2 == 0) ? "R6" : "R10");

    // conveyor: sequencer reads while a line loads
    fork
      send_line($urandom, {$urandom, $urandom}, 2, 1'b0);
      begin
        for (int k = 0; k < 5; k++) begin
          read_check(1, "R9");
          repeat (3) @(negedge clk);
        end
      end
    join
    read_check(31, "R6");

    // fill to the top, then wrap with a same-address read
    while (lines_loaded < 256) send_line($urandom, {$urandom, $urandom}, 0, 1'b0);
    chk(exp_addr == 0, "R7", "model at wrap point", 96'(exp_addr), 96'd0);
    send_line(32'h0000_FFFE, 64'hF0F0_0F0F_AAAA_5555, 0, 1'b1);
    read_check(0, "R7");
    read_check(255, "R7");
    read_check(1, "R7");

    // reset in the middle of a line
    for (int i = 0; i < 3; i++) send_word(16'h7777, 0, 1'b0, 0, '0);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(rx_ready_o === 1'b0, "R8", "ready in mid-line reset", 96'(rx_ready_o), 96'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    exp_addr = 0;
    send_line(32'h1357_9BDF, 64'h2468_ACE0_1122_3344, 1, 1'b0);
    read_check(0, "R8");
    read_check(1, "R8");
    read_check(2, "R8");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule